// File: doc/BRIEF.md
# Register Rename Stage with Idiom Elimination

This block is the rename stage of a small out-of-order core. Each cycle it may take a group of up to four decoded micro-ops. Each micro-op carries a destination, two sources, an opcode class and an immediate flag. The stage looks up physical registers for the sources and assigns a physical register to the destination. It also hands out reorder-buffer indices and reports, per micro-op, whether an execution unit is needed.

Two kinds of operation are finished inside the rename map and are never dispatched. The first is a subtract or exclusive-or of a register with itself, which always yields zero. The second is a plain register-to-register move. A zeroing op receives a fresh physical register that is already known to hold zero. An eliminated move makes its destination share the physical register that its source currently maps to. Every physical register has a small saturating share count. A move whose source register is already shared the maximum number of times is executed as an ordinary micro-op instead.

On the commit side, retiring micro-ops hand back the physical register their destination previously mapped to. That register returns to the free pool only once nothing else shares it.

Top module: `rn_idiom_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers ARCH_REGS to PHYS_REGS-1 are free, every share count is zero, and the first reorder index handed out is 0.
- R2: A micro-op with class 1 (subtract) or class 2 (exclusive-or), with the immediate flag clear and equal source registers, is renamed with kind 1 (zero). Its needs-exec flag is 0 and it gets a newly allocated physical register.
- R3: A group of four zeroing micro-ops is accepted in a single cycle, and none of the four needs an execution unit.
- R4: Class 4 (no-op) is renamed with kind 3. It has needs-exec 0, takes no physical register and leaves the map unchanged, but it still consumes a reorder index.
- R5: Class 3 (move) with the immediate flag set is a load of an immediate value, including zero. It is renamed with kind 0 (executed), needs-exec 1 and a new physical register.
- R6: Class 3 with the immediate flag clear is eliminated when its source's physical register has a share count below 3. It gets kind 2, needs-exec 0, a destination equal to the source's current physical register, and that register's share count goes up by one.
- R7: A move whose source was itself written by an eliminated move gets the same physical register as the original.
- R8: A move whose source register's share count is already 3 falls back to kind 0 with a newly allocated destination.
- R9: A subtract with an immediate, a subtract or exclusive-or of two different registers, and consecutive writes to the same destination are each renamed with kind 0 and needs-exec 1.
- R10: Inside a group, each micro-op's sources and previous-destination mapping reflect all earlier micro-ops of the same group, eliminated moves included.
- R11: Ready is low whenever the group needs more new physical registers than are free, or more reorder slots than are free. A group that is not accepted leaves every mapping, count and pointer unchanged.
- R12: New physical registers go to the lowest-numbered free registers, in lane order. A commit lane with a release flag decrements the named register's share count, or frees the register if its count is already zero.
- R13: Reorder indices are consecutive modulo ROB_DEPTH across the valid lanes in lane order. A commit lane retires one reorder slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A rename group is offered |
| in_ready | output | 1 | The offered group fits and will be accepted |
| in_lane_valid | input | LANES | Lane holds a micro-op |
| in_class | input | 3*LANES | Opcode class per lane: 0 alu, 1 sub, 2 xor, 3 move, 4 no-op, others alu |
| in_dst | input | AW*LANES | Architectural destination |
| in_src_a | input | AW*LANES | First architectural source |
| in_src_b | input | AW*LANES | Second architectural source |
| in_imm | input | LANES | Second operand is an immediate |
| out_fire | output | 1 | Group accepted this cycle |
| out_kind | output | 2*LANES | 0 executed, 1 zero, 2 move, 3 no-op |
| out_needs_exec | output | LANES | Lane must be dispatched |
| out_pdst | output | PW*LANES | Physical destination |
| out_pold | output | PW*LANES | Previous physical mapping of the destination |
| out_psrc_a | output | PW*LANES | Physical first source |
| out_psrc_b | output | PW*LANES | Physical second source |
| out_rob_idx | output | RW*LANES | Reorder index |
| cm_valid | input | LANES | Commit lane retires one reorder slot |
| cm_has_old | input | LANES | Commit lane releases a physical register |
| cm_old_preg | input | PW*LANES | Physical register released |

## Verification
A corrupted map entry is visible within a cycle: the next micro-op that reads that architectural register shows a wrong physical source or previous mapping. A wrong share count takes longer to show. It surfaces when a chain of moves reaches the limit and the fourth or fifth move gets the wrong kind, or at release time, when a register comes back too early or too late. That in turn shows up as a wrong lowest-free allocation on a later group. Drift in the free pool or the reorder count shows at the ready output during full-pressure phases, where the exact cycle of the stall is compared with a model.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam logic [2:0] OPC_ALU = 3'd0;
    localparam logic [2:0] OPC_SUB = 3'd1;
    localparam logic [2:0] OPC_XOR = 3'd2;
    localparam logic [2:0] OPC_MOV = 3'd3;
    localparam logic [2:0] OPC_NOP = 3'd4;

    typedef enum logic [1:0] {
        RK_EXEC = 2'd0,
        RK_ZERO = 2'd1,
        RK_MOVE = 2'd2,
        RK_NOP  = 2'd3
    } rn_kind_e;

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int PHYS_REGS = 48,
    parameter int ARCH_REGS = 16,
    parameter int LANES     = 4,
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_go,
    input  logic [CW-1:0]                 alloc_cnt,
    input  logic [PHYS_REGS-1:0]          release_mask,
    output logic [LANES-1:0][PW-1:0]      pick,
    output logic [PW:0]                   free_cnt
);

    logic [PHYS_REGS-1:0] free_q;
    logic [PHYS_REGS-1:0] remain;
    logic [PHYS_REGS-1:0] taken;
    logic                 found;

    // lowest-first picks, one per lane slot
    always_comb begin
        remain = free_q;
        taken  = '0;
        pick   = '0;
        for (int l = 0; l < LANES; l++) begin
            found = 1'b0;
            for (int p = 0; p < PHYS_REGS; p++) begin
                if (!found && remain[p]) begin
                    pick[l] = PW'(p);
                    found   = 1'b1;
                end
            end
            if (found) begin
                remain[pick[l]] = 1'b0;
                if (CW'(l) < alloc_cnt) begin
                    taken[pick[l]] = 1'b1;
                end
            end
        end
        free_cnt = (PW+1)'($countones(free_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHYS_REGS; p++) begin
                free_q[p] <= (p >= ARCH_REGS);
            end
        end else begin
            free_q <= (free_q & ~(alloc_go ? taken : '0)) | release_mask;
        end
    end

    a_r12_no_double_free: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask & free_q) == '0);

    a_r11_alloc_covered: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |-> ((PW+1)'(alloc_cnt) <= free_cnt));

endmodule

// File: rtl/rn_share_cnt.sv
module rn_share_cnt #(
    parameter int PHYS_REGS = 48,
    parameter int LANES     = 4,
    parameter int SHARE_W   = 2,
    localparam int PW   = $clog2(PHYS_REGS),
    localparam int SMAX = (1 << SHARE_W) - 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               apply_inc,
    input  logic [LANES-1:0]                   inc_en,
    input  logic [LANES-1:0][PW-1:0]           inc_preg,
    input  logic [LANES-1:0]                   rel_en,
    input  logic [LANES-1:0][PW-1:0]           rel_preg,
    output logic [PHYS_REGS-1:0][SHARE_W-1:0]  cnt,
    output logic [PHYS_REGS-1:0]               release_mask
);

    logic [PHYS_REGS-1:0][SHARE_W-1:0] cnt_q;
    logic [PHYS_REGS-1:0][SHARE_W-1:0] work;
    logic                              wrap;

    assign cnt = cnt_q;

    always_comb begin
        work         = cnt_q;
        release_mask = '0;
        wrap         = 1'b0;
        // releases see the counts before this cycle's new shares
        for (int l = 0; l < LANES; l++) begin
            if (rel_en[l]) begin
                if (work[rel_preg[l]] == '0) begin
                    release_mask[rel_preg[l]] = 1'b1;
                end else begin
                    work[rel_preg[l]] = work[rel_preg[l]] - SHARE_W'(1);
                end
            end
        end
        for (int l = 0; l < LANES; l++) begin
            if (apply_inc && inc_en[l]) begin
                if (work[inc_preg[l]] == SHARE_W'(SMAX)) begin
                    wrap = 1'b1;
                end
                work[inc_preg[l]] = work[inc_preg[l]] + SHARE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= work;
        end
    end

    a_r8_share_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap);

endmodule

// File: rtl/rn_group_rename.sv
module rn_group_rename
    import rn_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 48,
    parameter int SHARE_W   = 2,
    localparam int AW   = $clog2(ARCH_REGS),
    localparam int PW   = $clog2(PHYS_REGS),
    localparam int CW   = $clog2(LANES + 1),
    localparam int SMAX = (1 << SHARE_W) - 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fire,
    input  logic [LANES-1:0]                   lane_valid,
    input  logic [LANES-1:0][2:0]              cls,
    input  logic [LANES-1:0][AW-1:0]           dst,
    input  logic [LANES-1:0][AW-1:0]           src_a,
    input  logic [LANES-1:0][AW-1:0]           src_b,
    input  logic [LANES-1:0]                   imm,
    input  logic [LANES-1:0][PW-1:0]           pick,
    input  logic [PHYS_REGS-1:0][SHARE_W-1:0]  cnt,
    output logic [LANES-1:0][1:0]              kind,
    output logic [LANES-1:0][PW-1:0]           pdst,
    output logic [LANES-1:0][PW-1:0]           pold,
    output logic [LANES-1:0][PW-1:0]           psrc_a,
    output logic [LANES-1:0][PW-1:0]           psrc_b,
    output logic [CW-1:0]                      alloc_cnt,
    output logic [LANES-1:0]                   inc_en,
    output logic [LANES-1:0][PW-1:0]           inc_preg
);

    logic [ARCH_REGS-1:0][PW-1:0]      map_q;
    logic [ARCH_REGS-1:0][PW-1:0]      wmap;
    logic [PHYS_REGS-1:0][SHARE_W-1:0] wcnt;
    logic                              is_zero;
    logic                              can_move;
    int                                kk;

    // lanes walk in order over a working copy of map and counts
    always_comb begin
        wmap     = map_q;
        wcnt     = cnt;
        kk       = 0;
        kind     = '0;
        pdst     = '0;
        pold     = '0;
        psrc_a   = '0;
        psrc_b   = '0;
        inc_en   = '0;
        inc_preg = '0;
        is_zero  = 1'b0;
        can_move = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            kind[l]   = RK_NOP;
            psrc_a[l] = wmap[src_a[l]];
            psrc_b[l] = wmap[src_b[l]];
            is_zero   = ((cls[l] == OPC_SUB) || (cls[l] == OPC_XOR))
                        && !imm[l] && (src_a[l] == src_b[l]);
            can_move  = (cls[l] == OPC_MOV) && !imm[l]
                        && (wcnt[psrc_a[l]] != SHARE_W'(SMAX));
            if (lane_valid[l] && (cls[l] != OPC_NOP)) begin
                pold[l] = wmap[dst[l]];
                if (is_zero) begin
                    kind[l] = RK_ZERO;
                    pdst[l] = pick[kk];
                    kk      = kk + 1;
                end else if (can_move) begin
                    kind[l]           = RK_MOVE;
                    pdst[l]           = psrc_a[l];
                    inc_en[l]         = 1'b1;
                    inc_preg[l]       = psrc_a[l];
                    wcnt[psrc_a[l]]   = wcnt[psrc_a[l]] + SHARE_W'(1);
                end else begin
                    kind[l] = RK_EXEC;
                    pdst[l] = pick[kk];
                    kk      = kk + 1;
                end
                wmap[dst[l]] = pdst[l];
            end
        end
        alloc_cnt = CW'(kk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                map_q[a] <= PW'(a);
            end
        end else if (fire) begin
            map_q <= wmap;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        a_r2_zero_fresh: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && lane_valid[g] && kind[g] == RK_ZERO) |-> (pdst[g] != pold[g]));
        if (g > 0) begin : g_fwd
            a_r10_group_forward: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_valid[g] && lane_valid[g-1] && cls[g-1] != OPC_NOP
                 && src_a[g] == dst[g-1]) |-> (psrc_a[g] == pdst[g-1]));
        end
    end

endmodule

// File: rtl/rn_idiom_rename.sv
module rn_idiom_rename
    import rn_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 48,
    parameter int ROB_DEPTH = 32,
    parameter int SHARE_W   = 2,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int RW = $clog2(ROB_DEPTH),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES-1:0]      in_lane_valid,
    input  logic [3*LANES-1:0]    in_class,
    input  logic [AW*LANES-1:0]   in_dst,
    input  logic [AW*LANES-1:0]   in_src_a,
    input  logic [AW*LANES-1:0]   in_src_b,
    input  logic [LANES-1:0]      in_imm,
    output logic                  out_fire,
    output logic [2*LANES-1:0]    out_kind,
    output logic [LANES-1:0]      out_needs_exec,
    output logic [PW*LANES-1:0]   out_pdst,
    output logic [PW*LANES-1:0]   out_pold,
    output logic [PW*LANES-1:0]   out_psrc_a,
    output logic [PW*LANES-1:0]   out_psrc_b,
    output logic [RW*LANES-1:0]   out_rob_idx,
    input  logic [LANES-1:0]      cm_valid,
    input  logic [LANES-1:0]      cm_has_old,
    input  logic [PW*LANES-1:0]   cm_old_preg
);

    logic [LANES-1:0][2:0]              cls;
    logic [LANES-1:0][AW-1:0]           dst, src_a, src_b;
    logic [LANES-1:0][PW-1:0]           pick, pdst, pold, psa, psb, inc_preg, rel_preg;
    logic [LANES-1:0][1:0]              kind;
    logic [LANES-1:0]                   inc_en;
    logic [PHYS_REGS-1:0][SHARE_W-1:0]  cnt;
    logic [PHYS_REGS-1:0]               release_mask;
    logic [CW-1:0]                      alloc_cnt, n_valid, n_commit;
    logic [PW:0]                        free_cnt;
    logic [RW:0]                        rob_count, rob_free;
    logic [RW-1:0]                      rob_tail;
    logic [RW+1:0]                      idx_sum;
    logic [LANES-1:0][RW-1:0]           rob_idx;
    logic                               fire;
    int                                 off;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign cls[g]      = in_class[3*g +: 3];
        assign dst[g]      = in_dst[AW*g +: AW];
        assign src_a[g]    = in_src_a[AW*g +: AW];
        assign src_b[g]    = in_src_b[AW*g +: AW];
        assign rel_preg[g] = cm_old_preg[PW*g +: PW];
        assign out_kind[2*g +: 2]      = kind[g];
        assign out_needs_exec[g]       = in_lane_valid[g] && (kind[g] == RK_EXEC);
        assign out_pdst[PW*g +: PW]    = pdst[g];
        assign out_pold[PW*g +: PW]    = pold[g];
        assign out_psrc_a[PW*g +: PW]  = psa[g];
        assign out_psrc_b[PW*g +: PW]  = psb[g];
        assign out_rob_idx[RW*g +: RW] = rob_idx[g];
    end

    rn_freelist #(
        .PHYS_REGS (PHYS_REGS),
        .ARCH_REGS (ARCH_REGS),
        .LANES     (LANES)
    ) u_free (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_go     (fire),
        .alloc_cnt    (alloc_cnt),
        .release_mask (release_mask),
        .pick         (pick),
        .free_cnt     (free_cnt)
    );

    rn_share_cnt #(
        .PHYS_REGS (PHYS_REGS),
        .LANES     (LANES),
        .SHARE_W   (SHARE_W)
    ) u_share (
        .clk          (clk),
        .rst_n        (rst_n),
        .apply_inc    (fire),
        .inc_en       (inc_en),
        .inc_preg     (inc_preg),
        .rel_en       (cm_valid & cm_has_old),
        .rel_preg     (rel_preg),
        .cnt          (cnt),
        .release_mask (release_mask)
    );

    rn_group_rename #(
        .LANES     (LANES),
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .SHARE_W   (SHARE_W)
    ) u_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .lane_valid (in_lane_valid),
        .cls        (cls),
        .dst        (dst),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm        (in_imm),
        .pick       (pick),
        .cnt        (cnt),
        .kind       (kind),
        .pdst       (pdst),
        .pold       (pold),
        .psrc_a     (psa),
        .psrc_b     (psb),
        .alloc_cnt  (alloc_cnt),
        .inc_en     (inc_en),
        .inc_preg   (inc_preg)
    );

    always_comb begin
        n_valid  = CW'($countones(in_lane_valid));
        n_commit = CW'($countones(cm_valid));
        rob_free = (RW+1)'(ROB_DEPTH) - rob_count;
        in_ready = ((PW+1)'(alloc_cnt) <= free_cnt) && ((RW+1)'(n_valid) <= rob_free);
        fire     = in_valid && in_ready;
        off      = 0;
        idx_sum  = '0;
        rob_idx  = '0;
        for (int l = 0; l < LANES; l++) begin
            idx_sum = (RW+2)'(rob_tail) + (RW+2)'(off);
            if (idx_sum >= (RW+2)'(ROB_DEPTH)) begin
                idx_sum = idx_sum - (RW+2)'(ROB_DEPTH);
            end
            rob_idx[l] = idx_sum[RW-1:0];
            if (in_lane_valid[l]) begin
                off = off + 1;
            end
        end
    end

    assign out_fire = fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rob_count <= '0;
            rob_tail  <= '0;
        end else begin
            rob_count <= rob_count + (fire ? (RW+1)'(n_valid) : '0) - (RW+1)'(n_commit);
            if (fire) begin
                rob_tail <= ((RW+2)'(rob_tail) + (RW+2)'(n_valid) >= (RW+2)'(ROB_DEPTH))
                          ? RW'((RW+2)'(rob_tail) + (RW+2)'(n_valid) - (RW+2)'(ROB_DEPTH))
                          : RW'((RW+2)'(rob_tail) + (RW+2)'(n_valid));
            end
        end
    end

    a_r13_rob_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rob_count <= (RW+1)'(ROB_DEPTH));

    a_r13_commit_le_count: assert property (@(posedge clk) disable iff (!rst_n)
        (RW+1)'(n_commit) <= rob_count);

    a_r11_hold_tail: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(rob_tail));

endmodule

// File: tb/tb_rn_idiom_rename.sv
`timescale 1ns/100ps
module tb_rn_idiom_rename;

    localparam int L = 4, AR = 16, PR = 48, RD = 32, AW = 4, PW = 6, RW = 5, SMAX = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid, in_ready, out_fire;
    logic [L-1:0] in_lane_valid, in_imm, out_needs_exec, cm_valid, cm_has_old;
    logic [3*L-1:0] in_class;
    logic [AW*L-1:0] in_dst, in_src_a, in_src_b;
    logic [2*L-1:0] out_kind;
    logic [PW*L-1:0] out_pdst, out_pold, out_psrc_a, out_psrc_b, cm_old_preg;
    logic [RW*L-1:0] out_rob_idx;

    always #2.5 clk = ~clk;

    rn_idiom_rename dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_lane_valid(in_lane_valid), .in_class(in_class), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
        .out_fire(out_fire), .out_kind(out_kind), .out_needs_exec(out_needs_exec),
        .out_pdst(out_pdst), .out_pold(out_pold), .out_psrc_a(out_psrc_a),
        .out_psrc_b(out_psrc_b), .out_rob_idx(out_rob_idx),
        .cm_valid(cm_valid), .cm_has_old(cm_has_old), .cm_old_preg(cm_old_preg)
    );

    int n_chk = 0, n_fail = 0;

    // stimulus for one group
    int t_v[L], t_c[L], t_d[L], t_a[L], t_b[L], t_i[L], t_inv;
    // model state
    int m_map[AR], m_cnt[PR], m_free[PR], q_has[64], q_old[64], q_head, q_cnt, m_tail;
    // predictions
    int e_kind[L], e_pdst[L], e_pold[L], e_psa[L], e_psb[L], e_rob[L], e_inc[L], e_ready;
    int p_map[AR], p_pick[L], p_nalloc, n_cm;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int a = 0; a < AR; a++) m_map[a] = a;
        for (int p = 0; p < PR; p++) begin m_cnt[p] = 0; m_free[p] = (p >= AR); end
        q_head = 0; q_cnt = 0; m_tail = 0;
    endtask

    task automatic predict();
        int tk[PR];
        int wcnt[PR];
        int kk, nv, nf, off, found;
        for (int p = 0; p < PR; p++) begin tk[p] = 0; wcnt[p] = m_cnt[p]; end
        for (int a = 0; a < AR; a++) p_map[a] = m_map[a];
        nf = 0;
        for (int p = 0; p < PR; p++) nf += m_free[p];
        for (int l = 0; l < L; l++) begin
            p_pick[l] = -1; found = 0;
            for (int p = 0; p < PR; p++)
                if (!found && m_free[p] && !tk[p]) begin p_pick[l] = p; tk[p] = 1; found = 1; end
        end
        kk = 0; nv = 0; off = 0;
        for (int l = 0; l < L; l++) begin
            e_kind[l] = 3; e_pdst[l] = 0; e_pold[l] = 0; e_inc[l] = -1;
            e_psa[l] = p_map[t_a[l]]; e_psb[l] = p_map[t_b[l]];
            e_rob[l] = (m_tail + off) % RD;
            if (t_v[l]) begin
                nv++; off++;
                if (t_c[l] != 4) begin
                    e_pold[l] = p_map[t_d[l]];
                    if ((t_c[l] == 1 || t_c[l] == 2) && !t_i[l] && t_a[l] == t_b[l]) begin
                        e_kind[l] = 1; e_pdst[l] = p_pick[kk]; kk++;
                    end else if (t_c[l] == 3 && !t_i[l] && wcnt[e_psa[l]] < SMAX) begin
                        e_kind[l] = 2; e_pdst[l] = e_psa[l]; wcnt[e_psa[l]]++; e_inc[l] = e_psa[l];
                    end else begin
                        e_kind[l] = 0; e_pdst[l] = p_pick[kk]; kk++;
                    end
                    p_map[t_d[l]] = e_pdst[l];
                end
            end
        end
        p_nalloc = kk;
        e_ready = (kk <= nf) && (nv <= RD - q_cnt);
    endtask

    task automatic drive();
        in_valid = !t_inv;
        for (int l = 0; l < L; l++) begin
            in_lane_valid[l] = t_v[l][0];
            in_imm[l] = t_i[l][0];
            in_class[3*l +: 3] = 3'(t_c[l]);
            in_dst[AW*l +: AW] = AW'(t_d[l]);
            in_src_a[AW*l +: AW] = AW'(t_a[l]);
            in_src_b[AW*l +: AW] = AW'(t_b[l]);
        end
        for (int l = 0; l < L; l++) begin
            cm_valid[l] = (l < n_cm);
            cm_has_old[l] = (l < n_cm) ? q_has[(q_head + l) % 64][0] : 1'b0;
            cm_old_preg[PW*l +: PW] = (l < n_cm) ? PW'(q_old[(q_head + l) % 64]) : '0;
        end
    endtask

    function automatic string ktag(input int l);
        if (e_kind[l] == 1) return "R2 kind";
        if (e_kind[l] == 2) return "R6 kind";
        if (e_kind[l] == 3) return "R4 kind";
        if (t_c[l] == 3) return (t_i[l] != 0) ? "R5 kind" : "R8 kind";
        return "R9 kind";
    endfunction

    task automatic compare();
        chk("R11 ready", int'(in_ready), e_ready);
        if (e_ready && !t_inv) begin
            for (int l = 0; l < L; l++) if (t_v[l]) begin
                chk(ktag(l), int'(out_kind[2*l +: 2]), e_kind[l]);
                chk("R9 needs_exec", int'(out_needs_exec[l]), int'(e_kind[l] == 0));
                chk("R13 rob_idx", int'(out_rob_idx[RW*l +: RW]), e_rob[l]);
                if (e_kind[l] != 3) begin
                    chk(e_kind[l] == 2 ? "R7 pdst" : "R12 pdst", int'(out_pdst[PW*l +: PW]), e_pdst[l]);
                    chk("R10 pold", int'(out_pold[PW*l +: PW]), e_pold[l]);
                end
                if (e_kind[l] == 0) begin
                    chk("R10 psrc_a", int'(out_psrc_a[PW*l +: PW]), e_psa[l]);
                    if (!t_i[l]) chk("R10 psrc_b", int'(out_psrc_b[PW*l +: PW]), e_psb[l]);
                end
            end
        end
    endtask

    task automatic apply();
        int fired;
        fired = e_ready && !t_inv;
        for (int c = 0; c < n_cm; c++) begin
            int qi;
            qi = (q_head + c) % 64;
            if (q_has[qi]) begin
                if (m_cnt[q_old[qi]] == 0) m_free[q_old[qi]] = 1;
                else m_cnt[q_old[qi]]--;
            end
        end
        q_head = (q_head + n_cm) % 64; q_cnt -= n_cm;
        if (fired) begin
            for (int a = 0; a < AR; a++) m_map[a] = p_map[a];
            for (int k = 0; k < p_nalloc; k++) m_free[p_pick[k]] = 0;
            for (int l = 0; l < L; l++) begin
                if (e_inc[l] >= 0) m_cnt[e_inc[l]]++;
                if (t_v[l]) begin
                    q_has[(q_head + q_cnt) % 64] = (e_kind[l] != 3);
                    q_old[(q_head + q_cnt) % 64] = e_pold[l];
                    q_cnt++; m_tail = (m_tail + 1) % RD;
                end
            end
        end
    endtask

    task automatic pre_cycle(input int ncm);
        @(negedge clk);
        n_cm = (ncm > q_cnt) ? q_cnt : ncm;
        drive();
        #1;
        predict();
        compare();
    endtask

    task automatic post_cycle();
        @(posedge clk);
        #1;
        apply();
    endtask

    task automatic set_lane(input int l, input int c, input int d, input int a, input int b, input int i);
        t_v[l] = 1; t_c[l] = c; t_d[l] = d; t_a[l] = a; t_b[l] = b; t_i[l] = i;
    endtask

    task automatic random_group();
        t_inv = ($urandom % 16 == 0);
        for (int l = 0; l < L; l++) begin
            int r;
            r = $urandom % 16;
            t_v[l] = ($urandom % 8 != 0);
            t_c[l] = (r < 4) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : (r < 12) ? 3 : (r == 12) ? 4 : 5 + (r % 3);
            t_d[l] = ($urandom % 4 == 0) ? $urandom % AR : $urandom % 6;
            t_a[l] = ($urandom % 4 == 0) ? $urandom % AR : $urandom % 6;
            t_b[l] = ($urandom % 3 == 0) ? t_a[l] : $urandom % 6;
            t_i[l] = ($urandom % 4 == 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL R11 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        t_inv = 1; n_cm = 0;
        for (int l = 0; l < L; l++) begin t_v[l] = 0; t_c[l] = 0; t_d[l] = 0; t_a[l] = 0; t_b[l] = 0; t_i[l] = 0; end
        drive();
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // four zeroing ops in one group (R1, R2, R3)
        t_inv = 0;
        set_lane(0, 2, 1, 1, 1, 0); set_lane(1, 1, 2, 2, 2, 0);
        set_lane(2, 2, 3, 3, 3, 0); set_lane(3, 1, 4, 4, 4, 0);
        pre_cycle(0);
        chk("R3 ready for four zeroing ops", int'(in_ready), 1);
        chk("R3 no exec for four zeroing ops", int'(out_needs_exec), 0);
        for (int l = 0; l < L; l++) begin
            chk("R1 reset map pold", int'(out_pold[PW*l +: PW]), l + 1);
            chk("R1 first free pdst", int'(out_pdst[PW*l +: PW]), AR + l);
            chk("R1 first rob idx", int'(out_rob_idx[RW*l +: RW]), l);
        end
        post_cycle();

        // load-immediate and a three-deep move chain (R5, R6, R7)
        set_lane(0, 3, 8, 0, 0, 1); set_lane(1, 3, 9, 1, 0, 0);
        set_lane(2, 3, 10, 9, 0, 0); set_lane(3, 3, 11, 10, 0, 0);
        pre_cycle(0);
        chk("R5 load imm executes", int'(out_needs_exec[0]), 1);
        chk("R5 load imm pdst", int'(out_pdst[0 +: PW]), 20);
        chk("R6 move kind", int'(out_kind[2 +: 2]), 2);
        chk("R6 move pdst", int'(out_pdst[PW +: PW]), 16);
        chk("R7 chained move pdst", int'(out_pdst[2*PW +: PW]), 16);
        chk("R7 chained move pdst lane3", int'(out_pdst[3*PW +: PW]), 16);
        post_cycle();

        // share limit reached, plus non-idioms and a no-op (R8, R9, R4)
        set_lane(0, 3, 12, 11, 0, 0); set_lane(1, 4, 13, 0, 0, 0);
        set_lane(2, 1, 5, 5, 5, 1); set_lane(3, 2, 6, 6, 7, 0);
        pre_cycle(0);
        chk("R8 fallback kind", int'(out_kind[1:0]), 0);
        chk("R8 fallback pdst", int'(out_pdst[0 +: PW]), 21);
        chk("R4 nop no exec", int'(out_needs_exec[1]), 0);
        chk("R4 nop rob idx", int'(out_rob_idx[RW +: RW]), 9);
        chk("R9 sub imm pdst", int'(out_pdst[2*PW +: PW]), 22);
        chk("R9 xor distinct exec", int'(out_needs_exec[3]), 1);
        post_cycle();

        // back-to-back writes to one destination (R9)
        set_lane(0, 3, 7, 0, 0, 1); set_lane(1, 3, 7, 0, 0, 1);
        t_v[2] = 0; t_v[3] = 0;
        pre_cycle(0);
        chk("R9 both writes exec", int'(out_needs_exec[1:0]), 3);
        chk("R10 second write sees first", int'(out_pold[PW +: PW]), 24);
        post_cycle();

        // random traffic with pressure phases that exhaust regs and rob slots
        for (int cyc = 0; cyc < 3000; cyc++) begin
            int ncm;
            random_group();
            if ((cyc % 500) < 60) ncm = 0;
            else ncm = ($urandom % 3 == 0) ? $urandom % 5 : 4;
            pre_cycle(ncm);
            post_cycle();
        end

        // drain and confirm all registers return (R12)
        t_inv = 1;
        for (int c = 0; c < 20; c++) begin pre_cycle(4); post_cycle(); end
        begin
            int nf;
            nf = 0;
            for (int p = 0; p < PR; p++) nf += m_free[p];
            t_inv = 0;
            for (int l = 0; l < L; l++) set_lane(l, 0, l, l, l, 1);
            pre_cycle(0);
            chk("R12 ready after drain", int'(in_ready), int'(nf >= 4));
            post_cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule